// File: doc/BRIEF.md
# Four-channel DMA bus arbiter with programmable levels

This block decides which of several DMA channels owns the shared system bus. Every channel drives a bus request, a programmable priority level, an init-fill lock flag and a blocking-copy flag. The arbiter returns a registered one-hot grant vector and a bus-hold indication. The bus fabric uses the hold indication to keep lower-priority masters, the CPU among them, off the bus.

Ownership changes only at item boundaries. A boundary is reached when the current owner withdraws its request or pulses `item_end` on the last cycle of a data item. When a boundary is reached, the requester with the largest level wins, and ties go to the lowest channel number. Two exceptions apply. A locked owner that is still requesting cannot be displaced. A blocking owner hands the bus over only to a strictly higher level.

Top module: `dma_prio_arbiter`

## Requirements
- R1: During and directly after a synchronous active-low reset, `grant` is 4'b0000 and `bus_hold` is 0.
- R2: When no channel requests, `grant` is all zero on the following cycle.
- R3: With no current owner, the requesting channel with the numerically largest level wins. Channel i's level is `prio[3*i+2:3*i]`, where 3'b111 is the highest and 3'b000 the lowest.
- R4: When two or more requesters share the largest level, the one with the lowest channel index wins.
- R5: `grant` is a register. It reflects the requests sampled at the previous rising edge, it never has more than one bit set, and it is never given to a channel that was not requesting.
- R6: An owner that keeps requesting and does not pulse `item_end` keeps the grant, even if a higher-level channel requests.
- R7: When an owner that is neither locked nor blocking pulses `item_end` while still requesting, arbitration is rerun over all requesters, the owner included.
- R8: When the owner drops its request, it loses the grant on the next cycle, and the grant goes to the best remaining requester (or to nobody).
- R9: An owner whose `lock[i]` is 1 keeps the grant as long as it requests, whatever `item_end` and the other channels do.
- R10: When an owner with `blocking[i]` set (and lock clear) pulses `item_end`, it keeps the grant unless some requester has a strictly larger level. In that case the best requester takes over.
- R11: `bus_hold` is 1 exactly when the granted channel has its `lock` or `blocking` bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 4 | Bus request per channel |
| prio | input | 12 | Level per channel, 3 bits each, channel i at bits 3i+2..3i |
| lock | input | 4 | Channel is doing an init fill and must not be preempted |
| blocking | input | 4 | Channel runs a back-to-back copy that holds off lower levels |
| item_end | input | 1 | Current owner is on the last cycle of a data item |
| grant | output | 4 | Registered one-hot bus grant |
| bus_hold | output | 1 | Granted channel is locked or blocking; lower masters held off |

## Verification
A change on `req`, `prio`, `lock`, `blocking` or `item_end` shows up in `grant` after exactly one rising edge. `bus_hold` follows the registered grant and the present mode bits with no extra cycle. The bench drives every input on the falling edge and lets one rising edge pass. It then samples both outputs one nanosecond later and compares them with a model of the rules that is advanced by one step per edge. The sweep covers all sixteen request patterns under several level sets and mode sets, with `item_end` both high and low.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the DMA bus arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package dma_arb_pkg;

    // Reason behind the next grant value, used for readability and checks.
    typedef enum logic [2:0] {
        CAUSE_FREE     = 3'd0,  // no owner, open arbitration
        CAUSE_RELEASE  = 3'd1,  // owner dropped request
        CAUSE_LOCKED   = 3'd2,  // init-fill owner holds the bus
        CAUSE_MIDITEM  = 3'd3,  // owner is inside an item
        CAUSE_BLOCKING = 3'd4,  // blocking owner at item end
        CAUSE_REARB    = 3'd5   // plain owner at item end
    } arb_cause_e;

endpackage

// File: rtl/dma_arb_pick.sv
// Module: combinational winner search over all requesting channels.
// Picks the largest level; on equal levels the lower index is kept.
// Assumes: prio is packed with channel i at bits [PW*i +: PW].
module dma_arb_pick #(
    parameter int N  = 4,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);

    // Linear scan: a later channel replaces the best only on a strictly larger level.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                if (!found || (prio[PW*i +: PW] > win_prio)) begin
                    found    = 1'b1;
                    win_idx  = IW'(i);
                    win_prio = prio[PW*i +: PW];
                end
            end
        end
    end

endmodule

// File: rtl/dma_arb_policy.sv
// Module: ownership policy; decides whether to keep the current owner
// or hand the bus to the winner found by dma_arb_pick.
// Assumes: grant_q is one-hot or zero (guaranteed by the top register).
module dma_arb_policy
    import dma_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    grant_q,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic [N-1:0]    lock,
    input  logic [N-1:0]    blocking,
    input  logic            item_end,
    input  logic            found,
    input  logic [IW-1:0]   win_idx,
    input  logic [PW-1:0]   win_prio,
    output logic [N-1:0]    grant_d,
    output arb_cause_e      cause
);

    logic          own_valid;
    logic [IW-1:0] own_idx;
    logic          own_req;
    logic          own_lock;
    logic          own_blk;
    logic [PW-1:0] own_prio;
    logic          take_win;
    logic [N-1:0]  win_vec;

    // Decode the owner index and its attributes from the one-hot grant.
    always_comb begin
        own_valid = |grant_q;
        own_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_q[i]) own_idx = IW'(i);
        end
        own_req  = req[own_idx];
        own_lock = lock[own_idx];
        own_blk  = blocking[own_idx];
        own_prio = prio[PW*own_idx +: PW];
    end

    // Apply the hand-over rules in order of precedence.
    always_comb begin
        take_win = 1'b0;
        cause    = CAUSE_FREE;
        if (!own_valid) begin
            take_win = 1'b1;
            cause    = CAUSE_FREE;
        end else if (!own_req) begin
            take_win = 1'b1;
            cause    = CAUSE_RELEASE;
        end else if (own_lock) begin
            cause    = CAUSE_LOCKED;
        end else if (!item_end) begin
            cause    = CAUSE_MIDITEM;
        end else if (own_blk) begin
            take_win = (win_prio > own_prio);
            cause    = CAUSE_BLOCKING;
        end else begin
            take_win = 1'b1;
            cause    = CAUSE_REARB;
        end
    end

    // Form the one-hot vector of the winner, one generate slice per channel.
    for (genvar g = 0; g < N; g++) begin : g_win
        assign win_vec[g] = found && (win_idx == IW'(g));
    end

    // Select the next grant value.
    always_comb begin
        grant_d = take_win ? win_vec : grant_q;
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: top of the DMA bus arbiter. Registers the grant and derives the
// bus-hold indication for lower-priority masters.
// Assumes: item_end is asserted by the owner on the last cycle of an item;
// it is ignored when there is no owner.
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    input  logic [N-1:0]    lock,
    input  logic [N-1:0]    blocking,
    input  logic            item_end,
    output logic [N-1:0]    grant,
    output logic            bus_hold
);

    logic          found;
    logic [IW-1:0] win_idx;
    logic [PW-1:0] win_prio;
    logic [N-1:0]  grant_d;
    logic [N-1:0]  grant_q;
    arb_cause_e    cause;

    dma_arb_pick #(.N(N), .PW(PW)) pick_i (
        .req      (req),
        .prio     (prio),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    dma_arb_policy #(.N(N), .PW(PW)) policy_i (
        .grant_q  (grant_q),
        .req      (req),
        .prio     (prio),
        .lock     (lock),
        .blocking (blocking),
        .item_end (item_end),
        .found    (found),
        .win_idx  (win_idx),
        .win_prio (win_prio),
        .grant_d  (grant_d),
        .cause    (cause)
    );

    // Grant register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= grant_d;
    end

    assign grant    = grant_q;
    assign bus_hold = |(grant_q & (lock | blocking));

    // R5: never more than one grant bit.
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R2: nobody requesting means nobody granted next cycle.
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (grant_q == '0));

    // R11: hold implies an owner exists.
    a_r11_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hold |-> (grant_q != '0));

    for (genvar c = 0; c < N; c++) begin : g_chk
        // R5: a grant only goes to a channel that requested the cycle before.
        a_r5_req_first: assert property (@(posedge clk) disable iff (!rst_n)
            !req[c] |=> !grant_q[c]);
        // R8: an owner that drops its request is released.
        a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[c] && !req[c]) |=> !grant_q[c]);
        // R6: no hand-over in the middle of an item.
        a_r6_mid_item: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[c] && req[c] && !item_end) |=> grant_q[c]);
        // R9: a locked requesting owner is never preempted.
        a_r9_lock: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[c] && req[c] && lock[c]) |=> grant_q[c]);
    end

endmodule

// File: tb/dma_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_prio_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic [11:0] prio = '0;
    logic [3:0]  lock = '0;
    logic [3:0]  blocking = '0;
    logic        item_end = 1'b0;
    logic [3:0]  grant;
    logic        bus_hold;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_g = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dma_prio_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .lock(lock),
        .blocking(blocking), .item_end(item_end), .grant(grant), .bus_hold(bus_hold)
    );

    task automatic check(input string tag, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    function automatic int lvl(input logic [11:0] p, input int i);
        return int'(p[3*i +: 3]);
    endfunction

    // Best requester: scan levels from high to low, channels from low to high.
    function automatic int best(input logic [3:0] r, input logic [11:0] p);
        for (int l = 7; l >= 0; l--)
            for (int i = 0; i < 4; i++)
                if (r[i] && lvl(p, i) == l) return i;
        return -1;
    endfunction

    function automatic logic [3:0] vec(input int i);
        return (i < 0) ? 4'b0000 : (4'b0001 << i);
    endfunction

    // One arbitration step: drive at the falling edge, check after the rising edge.
    task automatic step(input logic [3:0] r, input logic e);
        int own;
        int w;
        logic [3:0] nxt;
        string tag;
        @(negedge clk);
        req = r; item_end = e;
        own = -1;
        for (int i = 0; i < 4; i++) if (exp_g[i]) own = i;
        w = best(r, prio);
        if (r == 4'b0) begin
            nxt = 4'b0; tag = "R2";
        end else if (own < 0) begin
            nxt = vec(w);
            tag = "R3";
            for (int i = 0; i < 4; i++)
                if (i != w && r[i] && lvl(prio, i) == lvl(prio, w)) tag = "R4";
        end else if (!r[own]) begin
            nxt = vec(w); tag = "R8";
        end else if (lock[own]) begin
            nxt = exp_g; tag = "R9";
        end else if (!e) begin
            nxt = exp_g; tag = "R6";
        end else if (blocking[own]) begin
            nxt = (lvl(prio, w) > lvl(prio, own)) ? vec(w) : exp_g; tag = "R10";
        end else begin
            nxt = vec(w); tag = "R7";
        end
        @(posedge clk);
        #1;
        check(tag, "grant", grant, nxt);
        check("R5", "one-hot", 4'($countones(grant) <= 1), 4'd1);
        check("R11", "bus_hold", {3'b0, bus_hold}, {3'b0, |(nxt & (lock | blocking))});
        exp_g = nxt;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] plist [4];
        logic [3:0]  llist [4];
        logic [3:0]  blist [4];
        plist[0] = {3'd4, 3'd4, 3'd4, 3'd4};
        plist[1] = {3'd7, 3'd5, 3'd2, 3'd0};
        plist[2] = {3'd0, 3'd1, 3'd6, 3'd7};
        plist[3] = {3'd7, 3'd2, 3'd5, 3'd5};
        llist[0] = 4'b0000; blist[0] = 4'b0000;
        llist[1] = 4'b0000; blist[1] = 4'b0101;
        llist[2] = 4'b0010; blist[2] = 4'b0000;
        llist[3] = 4'b0001; blist[3] = 4'b1000;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "grant in reset", grant, 4'b0000);
        check("R1", "bus_hold in reset", {3'b0, bus_hold}, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "grant after reset", grant, 4'b0000);

        for (int pi = 0; pi < 4; pi++) begin
            for (int mi = 0; mi < 4; mi++) begin
                @(negedge clk);
                prio = plist[pi]; lock = llist[mi]; blocking = blist[mi];
                for (int k = 0; k < 48; k++) begin
                    step(4'((k * 7 + pi + mi) % 16), logic'((k % 3) == 2));
                end
                step(4'b0000, 1'b0);
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule